// File: doc/BRIEF.md
# Data-Memory Access Unit with Pointer Indirection

This block is the data-side storage of a small 8-bit processor core. It holds a single 128-location bank. Special registers sit at the low addresses and 64 bytes of general RAM sit at 40h–7Fh. Each cycle the core presents one 7-bit address. It can write a byte and also hand in flag results from its ALU. The block returns the byte currently stored at the resolved location, combinationally, in the same cycle.

Address 00h is a virtual window. Any access to it is redirected to the location named by the 8-bit pointer register at 04h. The status register at 03h merges three sources under fixed precedence:
- ordinary writes;
- flag results from the ALU, selected by a per-flag mask;
- timeout and power-down events from the system.

Flag results follow the usual convention that, after a subtraction, the carry and digit-carry inputs already hold the inverted borrow and inverted digit borrow. The block stores them as presented.

Top module: `dmem_access_unit`

## Requirements
- R1: After reset the status register reads 18h (bit 4 timeout-flag = 1, bit 3 power-down flag = 1, all others 0), the pointer at 04h reads 00h, and every RAM byte reads 00h.
- R2: A write to a RAM address (40h–7Fh), to the pointer (04h) or to status bits 7:5 takes effect at the clock edge and is returned on the read port in the next cycle. Reads are combinational from the stored state.
- R3: An access to address 00h acts on the location given by bits 6:0 of the pointer. Pointer bit 7 and status bit 7 (the bank extension) are ignored, so every bank aliases onto this one.
- R4: When pointer bits 6:0 are 00h, an access to 00h reads 00h and its write changes no stored byte. Flag inputs presented in that cycle still update status.
- R5: Flag mask bit 2 selects Z (status bit 2), mask bit 1 selects DC (bit 1), mask bit 0 selects C (bit 0). A masked flag takes the flag-value input even if status is being written. While status is a write destination and the mask is non-zero, written bits 2:0 are discarded. Unmasked flags keep their value. With a zero mask, a status write loads bits 2:0 from the data.
- R6: Status bits 4 and 3 never take write data. A pulse on the timeout input clears bit 4, a pulse on the power-down input clears bit 3, and they stay clear until reset.
- R7: Writing 00h to status with mask 100b and flag value 100b leaves status as 000u u1uu (bits 7:5 cleared, Z set, bits 4, 3, 1 and 0 unchanged).
- R8: Status bits 7:5 are plain storage that write data loads and the read port returns.
- R9: Addresses 01h, 02h and 05h–3Fh read 00h and ignore writes, leaving status, pointer and RAM unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | 7 | Direct address within the bank |
| wr_en_i | input | 1 | Write strobe for the resolved location |
| wr_data_i | input | 8 | Write data |
| flag_mask_i | input | 3 | Flags affected this cycle: bit 2 Z, bit 1 DC, bit 0 C |
| flag_val_i | input | 3 | New flag values, same bit order as the mask |
| timeout_i | input | 1 | Timeout event, clears status bit 4 |
| powerdown_i | input | 1 | Power-down event, clears status bit 3 |
| rd_data_o | output | 8 | Byte stored at the resolved location |

## Verification
The bench goes after the pointer aimed at the window itself. A design that followed the pointer blindly would return the pointer or RAM contents instead of 00h, or corrupt a byte on the write. It also checks the clear-status pattern and a status write with a non-zero mask. A merge with the wrong precedence would load the written Z/DC/C bits or disturb unmasked flags. Pointer values with bit 7 set, and a set bank-extension bit, test the aliasing. A decoder that kept those bits would miss RAM. Writes to unimplemented addresses, and attempts to write the event-driven bits, catch decoders that leak into status or the pointer.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

   // status bit positions; the flag mask and flag value inputs share bits 2:0
   localparam int ST_C   = 0;
   localparam int ST_DC  = 1;
   localparam int ST_Z   = 2;
   localparam int ST_PD  = 3;
   localparam int ST_TO  = 4;
   localparam int ST_HI  = 5;   // lowest of the freely writable upper bits
   localparam int ST_W   = 8;
   localparam int FLAG_W = 3;

   localparam logic [ST_W-1:0] ST_RESET = 8'h18;

   typedef enum logic [1:0] {
      TGT_NONE,
      TGT_STATUS,
      TGT_POINTER,
      TGT_RAM
   } target_e;

endpackage

// File: rtl/rf_target_decode.sv
module rf_target_decode
   import dmem_pkg::*;
#(
   parameter int ADDR_W      = 7,
   parameter int INDF_ADDR   = 0,
   parameter int STATUS_ADDR = 3,
   parameter int PTR_ADDR    = 4,
   parameter int RAM_BASE    = 64,
   parameter int RAM_DEPTH   = 64,
   localparam int IDX_W      = $clog2(RAM_DEPTH)
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [ADDR_W-1:0] ptr_low_i,
   output logic [ADDR_W-1:0] eff_addr_o,
   output target_e           target_o,
   output logic [IDX_W-1:0]  ram_idx_o
);

   logic indirect;
   logic in_ram;

   assign indirect   = (addr_i == ADDR_W'(INDF_ADDR));
   assign eff_addr_o = indirect ? ptr_low_i : addr_i;
   assign ram_idx_o  = IDX_W'(eff_addr_o - ADDR_W'(RAM_BASE));

   // a RAM that reaches the top of the bank needs only a lower bound
   generate
      if (RAM_BASE + RAM_DEPTH == (1 << ADDR_W)) begin : g_ram_to_top
         assign in_ram = (eff_addr_o >= ADDR_W'(RAM_BASE));
      end else begin : g_ram_window
         assign in_ram = (eff_addr_o >= ADDR_W'(RAM_BASE)) &&
                         (eff_addr_o <  ADDR_W'(RAM_BASE + RAM_DEPTH));
      end
   endgenerate

   // a pointer that lands on the window itself resolves to no target
   always_comb begin
      if (eff_addr_o == ADDR_W'(STATUS_ADDR))    target_o = TGT_STATUS;
      else if (eff_addr_o == ADDR_W'(PTR_ADDR))  target_o = TGT_POINTER;
      else if (in_ram)                           target_o = TGT_RAM;
      else                                       target_o = TGT_NONE;
   end

endmodule

// File: rtl/rf_status_reg.sv
module rf_status_reg
   import dmem_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [ST_W-1:ST_HI] wr_hi_i,
   input  logic [FLAG_W-1:0] wr_lo_i,
   input  logic [FLAG_W-1:0] flag_mask_i,
   input  logic [FLAG_W-1:0] flag_val_i,
   input  logic              timeout_i,
   input  logic              powerdown_i,
   output logic [ST_W-1:0]   status_o
);

   logic [ST_W-1:0] st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (wr_i) begin
         st_d[ST_W-1:ST_HI] = wr_hi_i;
         if (flag_mask_i == '0) st_d[FLAG_W-1:0] = wr_lo_i;
      end
      for (int i = 0; i < FLAG_W; i++) begin
         if (flag_mask_i[i]) st_d[i] = flag_val_i[i];
      end
      if (timeout_i)   st_d[ST_TO] = 1'b0;
      if (powerdown_i) st_d[ST_PD] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_RESET;
      else        st_q <= st_d;
   end

   assign status_o = st_q;

   // R6
   event_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!timeout_i && !powerdown_i) |=> $stable(status_o[ST_TO:ST_PD]));

   // R6
   event_bits_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> !$rose(status_o[ST_TO]) && !$rose(status_o[ST_PD]));

   // R5
   z_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_mask_i[ST_Z] |=> status_o[ST_Z] == $past(flag_val_i[ST_Z]));

   // R5
   unmasked_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_mask_i[ST_C] && (flag_mask_i != '0)) |=> $stable(status_o[ST_C]));

endmodule

// File: rtl/rf_ram_bank.sv
module rf_ram_bank #(
   parameter int  DEPTH          = 64,
   parameter int  DATA_W         = 8,
   parameter bit  CLEAR_ON_RESET = 1'b1,
   localparam int IDX_W          = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o
);

   logic [DATA_W-1:0] cells [DEPTH];
   logic [DEPTH-1:0]  we_vec;

   generate
      for (genvar k = 0; k < DEPTH; k++) begin : g_cell
         logic [DATA_W-1:0] cell_q;
         assign we_vec[k] = we_i && (idx_i == IDX_W'(k));
         if (CLEAR_ON_RESET) begin : g_rst
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)         cell_q <= '0;
               else if (we_vec[k]) cell_q <= wdata_i;
            end
         end else begin : g_norst
            always_ff @(posedge clk) begin
               if (we_vec[k]) cell_q <= wdata_i;
            end
         end
         assign cells[k] = cell_q;
      end
   endgenerate

   assign rdata_o = cells[idx_i];

   // R2
   single_cell_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(we_vec));

   // R2
   written_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_i ##1 (idx_i == $past(idx_i)) |-> rdata_o == $past(wdata_i));

endmodule

// File: rtl/dmem_access_unit.sv
module dmem_access_unit
   import dmem_pkg::*;
#(
   parameter int ADDR_W         = 7,
   parameter int DATA_W         = 8,
   parameter int INDF_ADDR      = 0,
   parameter int STATUS_ADDR    = 3,
   parameter int PTR_ADDR       = 4,
   parameter int RAM_BASE       = 64,
   parameter int RAM_DEPTH      = 64,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int IDX_W         = $clog2(RAM_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [FLAG_W-1:0] flag_mask_i,
   input  logic [FLAG_W-1:0] flag_val_i,
   input  logic              timeout_i,
   input  logic              powerdown_i,
   output logic [DATA_W-1:0] rd_data_o
);

   // elaboration checks on the parameter set
   if (DATA_W != ST_W) begin : g_bad_width
      $error("status layout needs DATA_W equal to %0d", ST_W);
   end
   if (RAM_BASE + RAM_DEPTH > (1 << ADDR_W)) begin : g_bad_ram_span
      $error("RAM window exceeds the bank");
   end
   if (RAM_DEPTH != (1 << IDX_W)) begin : g_bad_ram_depth
      $error("RAM_DEPTH must be a power of two");
   end
   if (INDF_ADDR >= RAM_BASE || STATUS_ADDR >= RAM_BASE || PTR_ADDR >= RAM_BASE) begin : g_bad_special
      $error("special addresses must lie below RAM_BASE");
   end
   if (ADDR_W >= DATA_W) begin : g_bad_ptr
      $error("pointer must be wider than the bank address");
   end

   logic [DATA_W-1:0] ptr_q;
   logic [DATA_W-1:0] status;
   logic [DATA_W-1:0] ram_rd;
   logic [ADDR_W-1:0] eff_addr;
   logic [IDX_W-1:0]  ram_idx;
   target_e           tgt;
   logic              st_wr, ptr_wr, ram_wr;

   rf_target_decode #(
      .ADDR_W      (ADDR_W),
      .INDF_ADDR   (INDF_ADDR),
      .STATUS_ADDR (STATUS_ADDR),
      .PTR_ADDR    (PTR_ADDR),
      .RAM_BASE    (RAM_BASE),
      .RAM_DEPTH   (RAM_DEPTH)
   ) i_decode (
      .addr_i     (addr_i),
      .ptr_low_i  (ptr_q[ADDR_W-1:0]),
      .eff_addr_o (eff_addr),
      .target_o   (tgt),
      .ram_idx_o  (ram_idx)
   );

   assign st_wr  = wr_en_i && (tgt == TGT_STATUS);
   assign ptr_wr = wr_en_i && (tgt == TGT_POINTER);
   assign ram_wr = wr_en_i && (tgt == TGT_RAM);

   rf_status_reg i_status (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_i        (st_wr),
      .wr_hi_i     (wr_data_i[ST_W-1:ST_HI]),
      .wr_lo_i     (wr_data_i[FLAG_W-1:0]),
      .flag_mask_i (flag_mask_i),
      .flag_val_i  (flag_val_i),
      .timeout_i   (timeout_i),
      .powerdown_i (powerdown_i),
      .status_o    (status)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ptr_q <= '0;
      else if (ptr_wr) ptr_q <= wr_data_i;
   end

   rf_ram_bank #(
      .DEPTH          (RAM_DEPTH),
      .DATA_W         (DATA_W),
      .CLEAR_ON_RESET (CLEAR_ON_RESET)
   ) i_ram (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (ram_wr),
      .idx_i   (ram_idx),
      .wdata_i (wr_data_i),
      .rdata_o (ram_rd)
   );

   always_comb begin
      unique case (tgt)
         TGT_STATUS:  rd_data_o = status;
         TGT_POINTER: rd_data_o = ptr_q;
         TGT_RAM:     rd_data_o = ram_rd;
         default:     rd_data_o = '0;
      endcase
   end

   // R4
   self_ref_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_i == ADDR_W'(INDF_ADDR) && ptr_q[ADDR_W-1:0] == ADDR_W'(INDF_ADDR))
         |-> rd_data_o == '0);

   // R3
   indirect_follows_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_i == ADDR_W'(INDF_ADDR)) |-> eff_addr == ptr_q[ADDR_W-1:0]);

   // R9
   unimpl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && tgt == TGT_NONE && flag_mask_i == '0 && !timeout_i && !powerdown_i)
         |=> $stable(status) && $stable(ptr_q));

   // R2
   ptr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_wr |=> ptr_q == $past(wr_data_i));

endmodule

// File: tb/test_dmem_access_unit.sv
module test_dmem_access_unit;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] addr = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [2:0] fmask = '0;
   logic [2:0] fval = '0;
   logic       tmo = 1'b0;
   logic       pdn = 1'b0;
   logic [7:0] rd_data;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // bench model of the stored state
   logic [7:0] m_ram [64];
   logic [7:0] m_st;
   logic [7:0] m_ptr;

   always #10 clk = ~clk;

   dmem_access_unit i_dmem_access_unit (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr_i      (addr),
      .wr_en_i     (wr_en),
      .wr_data_i   (wr_data),
      .flag_mask_i (fmask),
      .flag_val_i  (fval),
      .timeout_i   (tmo),
      .powerdown_i (pdn),
      .rd_data_o   (rd_data)
   );

   function automatic logic [6:0] resolve(input logic [6:0] a);
      return (a == 7'h00) ? m_ptr[6:0] : a;
   endfunction

   function automatic logic [7:0] model_read(input logic [6:0] a);
      logic [6:0] e = resolve(a);
      if (e == 7'h03)       return m_st;
      else if (e == 7'h04)  return m_ptr;
      else if (e >= 7'h40)  return m_ram[e - 7'h40];
      else                  return 8'h00;
   endfunction

   task automatic model_step(input logic [6:0] a, input logic w, input logic [7:0] d,
                             input logic [2:0] mk, input logic [2:0] fv,
                             input logic to, input logic pd);
      logic [6:0] e = resolve(a);
      logic [7:0] nst = m_st;
      if (w) begin
         if (e == 7'h03) begin
            nst[7:5] = d[7:5];
            if (mk == 3'b000) nst[2:0] = d[2:0];
         end else if (e == 7'h04) begin
            m_ptr = d;
         end else if (e >= 7'h40) begin
            m_ram[e - 7'h40] = d;
         end
      end
      for (int i = 0; i < 3; i++) if (mk[i]) nst[i] = fv[i];
      if (to) nst[4] = 1'b0;
      if (pd) nst[3] = 1'b0;
      m_st = nst;
   endtask

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   // one cycle of stimulus; the read port is compared with the model before the edge
   task automatic op(input logic [6:0] a, input logic w, input logic [7:0] d,
                     input logic [2:0] mk, input logic [2:0] fv,
                     input logic to, input logic pd, input string req);
      @(negedge clk);
      addr = a; wr_en = w; wr_data = d; fmask = mk; fval = fv; tmo = to; pdn = pd;
      #1;
      chk(rd_data, model_read(a), req);
      @(posedge clk);
      model_step(a, w, d, mk, fv, to, pd);
   endtask

   // read with a literal expected value
   task automatic rd_exp(input logic [6:0] a, input logic [7:0] exp, input string req);
      @(negedge clk);
      addr = a; wr_en = 1'b0; wr_data = '0; fmask = '0; fval = '0; tmo = 1'b0; pdn = 1'b0;
      #1;
      chk(rd_data, exp, req);
      @(posedge clk);
   endtask

   task automatic wr(input logic [6:0] a, input logic [7:0] d,
                     input logic [2:0] mk, input logic [2:0] fv, input string req);
      op(a, 1'b1, d, mk, fv, 1'b0, 1'b0, req);
   endtask

   initial begin
      int seed_val;
      seed_val = $urandom(32'd20240611);
      for (int i = 0; i < 64; i++) m_ram[i] = 8'h00;
      m_st = 8'h18;
      m_ptr = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd_exp(7'h03, 8'h18, "R1 status");
      rd_exp(7'h04, 8'h00, "R1 pointer");
      rd_exp(7'h40, 8'h00, "R1 ram low");
      rd_exp(7'h7F, 8'h00, "R1 ram high");

      // R2 direct RAM
      wr(7'h40, 8'hA5, 3'b000, 3'b000, "R2");
      rd_exp(7'h40, 8'hA5, "R2 ram 40h");
      wr(7'h7F, 8'h3C, 3'b000, 3'b000, "R2");
      rd_exp(7'h7F, 8'h3C, "R2 ram 7Fh");

      // R8 upper status bits, R6 event bits unaffected by writes
      wr(7'h03, 8'hFF, 3'b000, 3'b000, "R8");
      rd_exp(7'h03, 8'hFF, "R8 status all ones");
      wr(7'h03, 8'h00, 3'b000, 3'b000, "R6");
      rd_exp(7'h03, 8'h18, "R6 event bits kept");

      // R7 clear-register pattern
      wr(7'h03, 8'hFF, 3'b000, 3'b000, "R7");
      wr(7'h03, 8'h00, 3'b100, 3'b100, "R7");
      rd_exp(7'h03, 8'h1F, "R7 clear pattern");

      // R5 masked write discards written flags
      wr(7'h03, 8'h00, 3'b000, 3'b000, "R5");
      wr(7'h03, 8'h07, 3'b010, 3'b000, "R5");
      rd_exp(7'h03, 8'h18, "R5 write with mask");
      op(7'h40, 1'b0, 8'h00, 3'b101, 3'b101, 1'b0, 1'b0, "R5");
      rd_exp(7'h03, 8'h1D, "R5 flag-only update");

      // R3 indirect with pointer bit 7 set
      wr(7'h04, 8'hC5, 3'b000, 3'b000, "R2");
      rd_exp(7'h04, 8'hC5, "R2 pointer");
      wr(7'h00, 8'h5A, 3'b000, 3'b000, "R3");
      rd_exp(7'h45, 8'h5A, "R3 indirect write");
      rd_exp(7'h00, 8'h5A, "R3 indirect read");
      // R3 bank extension bit ignored
      wr(7'h03, 8'h80, 3'b000, 3'b000, "R3");
      wr(7'h00, 8'h33, 3'b000, 3'b000, "R3");
      rd_exp(7'h45, 8'h33, "R3 bank bit ignored");

      // R4 pointer aimed at the window itself
      wr(7'h04, 8'h80, 3'b000, 3'b000, "R4");
      rd_exp(7'h00, 8'h00, "R4 self read");
      wr(7'h00, 8'h77, 3'b001, 3'b001, "R4");
      rd_exp(7'h03, 8'h99, "R4 flags still update");
      rd_exp(7'h04, 8'h80, "R4 pointer untouched");
      rd_exp(7'h40, 8'hA5, "R4 ram untouched");
      rd_exp(7'h00, 8'h00, "R4 self read after write");

      // R9 unimplemented addresses
      wr(7'h10, 8'hFF, 3'b000, 3'b000, "R9");
      rd_exp(7'h10, 8'h00, "R9 read 10h");
      rd_exp(7'h03, 8'h99, "R9 status kept");
      rd_exp(7'h04, 8'h80, "R9 pointer kept");
      wr(7'h02, 8'hFF, 3'b000, 3'b000, "R9");
      rd_exp(7'h02, 8'h00, "R9 read 02h");

      // R6 event inputs
      op(7'h40, 1'b0, 8'h00, 3'b000, 3'b000, 1'b1, 1'b0, "R6");
      rd_exp(7'h03, 8'h89, "R6 timeout clears bit 4");
      op(7'h40, 1'b0, 8'h00, 3'b000, 3'b000, 1'b0, 1'b1, "R6");
      rd_exp(7'h03, 8'h81, "R6 power-down clears bit 3");
      wr(7'h03, 8'hFF, 3'b000, 3'b000, "R6");
      rd_exp(7'h03, 8'hE7, "R6 bits not writable");

      // random traffic against the model
      for (int n = 0; n < 4000; n++) begin
         logic [6:0] a;
         logic [2:0] mk;
         int sel = $urandom_range(0, 7);
         if (sel < 2)       a = (sel == 0) ? 7'h00 : (($urandom_range(0, 1) == 0) ? 7'h03 : 7'h04);
         else if (sel < 6)  a = 7'h40 + 7'($urandom_range(0, 63));
         else               a = 7'($urandom_range(0, 127));
         mk = ($urandom_range(0, 1) == 0) ? 3'b000 : 3'($urandom);
         op(a, 1'($urandom), 8'($urandom), mk, 3'($urandom),
            ($urandom_range(0, 63) == 0), ($urandom_range(0, 63) == 0), "R2 R3 R5 random");
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R1: watchdog expired, actual hung expected finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule